// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate

This block is a signed multiply datapath with two families of operation. In the halfword family, one 16-bit half is picked from each 32-bit operand and the two are multiplied into an exact signed 32-bit product. In the word-by-halfword family, the whole first operand is multiplied by a picked half of the second operand. The middle 32 bits (bits 47:16) of the 48-bit signed product are kept.

Either result can be summed with a 32-bit accumulator. Signed overflow of that sum raises a one-cycle Q-set pulse and sets a sticky Q flag. Results wrap modulo 2^32 and are never saturated.

The block also receives the register indices of the operation and flags it as unpredictable when any index in use names the program counter. The result is registered once, with a valid bit. Decode and the register file sit outside the block.

Top module: `hs_mac`

## Requirements
- R1: With `mode_wh`=0, `sel_n`=1 picks bits 31:16 of `op_n` and `sel_n`=0 picks bits 15:0, each taken as signed 16-bit. `sel_m` picks the half of `op_m` in the same way. The product is the exact signed 32-bit product of the two halves.
- R2: With `acc_en`=0, the result is the product alone, and `q_set` stays 0 in both families.
- R3: With `acc_en`=1, the result is the product plus `acc` modulo 2^32. `q_set` is 1 exactly when that addition overflows as a signed 32-bit sum.
- R4: With `mode_wh`=1, the signed 32-bit `op_n` is multiplied by the signed half of `op_m` chosen by `sel_m` (1 = bits 31:16). The product is bits 47:16 of the 48-bit signed result. `sel_n` has no effect in this family.
- R5: With `mode_wh`=1 and `acc_en`=1, the truncated product is added to `acc`, and Q overflow is detected on that addition.
- R6: Overflowing sums wrap modulo 2^32; no saturation is applied to `result`.
- R7: `unpred` is 1 when `idx_d`, `idx_n` or `idx_m` equals 15, or when `acc_en`=1 and `idx_a` equals 15. Otherwise it is 0.
- R8: `out_valid`, `result`, `q_set` and `unpred` appear one clock after an accepted `in_valid`. `out_valid` and `q_set` are 0 in a cycle that follows no input. `result` holds its last value while idle.
- R9: After reset, `q_flag`, `out_valid`, `q_set`, `unpred` and `result` are 0. `q_flag` becomes 1 together with the first `q_set` and then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| mode_wh | input | 1 | 0 = halfword by halfword, 1 = word by halfword |
| acc_en | input | 1 | Add accumulator to product |
| sel_n | input | 1 | Half select for op_n (1 = top) |
| sel_m | input | 1 | Half select for op_m (1 = top) |
| op_n | input | 32 | First operand |
| op_m | input | 32 | Second operand |
| acc | input | 32 | Accumulator |
| idx_d | input | 4 | Destination register index |
| idx_n | input | 4 | First operand register index |
| idx_m | input | 4 | Second operand register index |
| idx_a | input | 4 | Accumulator register index |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Registered result |
| q_set | output | 1 | Overflow pulse for this result |
| q_flag | output | 1 | Sticky overflow flag |
| unpred | output | 1 | Operation used register 15 |

## Verification
The bench builds the block with its defaults: 32-bit data, 16-bit halves, 4-bit register indices and program counter index 15. At this width, every extreme half value is within reach: -32768 by -32768 in both families, and a full-scale word times a full-scale half. The directed cases include these. The directed cases also push the accumulate sum across both signed limits, so that wrapping and the Q pulse can be seen. Random operations mix both families, all select combinations and sparse register-15 indices, including index 15 on the accumulator when accumulation is off.

// File: rtl/hs_mac.sv
module hs_mac #(
  parameter int DW     = 32,
  parameter int RW     = 4,
  parameter int PC_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          mode_wh,
  input  logic          acc_en,
  input  logic          sel_n,
  input  logic          sel_m,
  input  logic [DW-1:0] op_n,
  input  logic [DW-1:0] op_m,
  input  logic [DW-1:0] acc,
  input  logic [RW-1:0] idx_d,
  input  logic [RW-1:0] idx_n,
  input  logic [RW-1:0] idx_m,
  input  logic [RW-1:0] idx_a,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          q_set,
  output logic          q_flag,
  output logic          unpred
);
  localparam int HW = DW / 2;
  localparam int PW = DW + HW;
  localparam logic [RW-1:0] PC = RW'(PC_IDX);

  logic [HW-1:0] half_n, half_m;
  logic [PW-1:0] ext_n, ext_m, prod_full;
  logic [DW-1:0] prod, sum;
  logic          ovf, bad;

  assign half_n = sel_n ? op_n[DW-1:HW] : op_n[HW-1:0];
  assign half_m = sel_m ? op_m[DW-1:HW] : op_m[HW-1:0];

  // one shared multiplier: operands sign-extended to the widest product
  assign ext_n = mode_wh ? {{HW{op_n[DW-1]}}, op_n} : {{DW{half_n[HW-1]}}, half_n};
  assign ext_m = {{DW{half_m[HW-1]}}, half_m};
  assign prod_full = ext_n * ext_m;
  assign prod = mode_wh ? prod_full[PW-1:HW] : prod_full[DW-1:0];

  assign sum = prod + acc;
  assign ovf = acc_en && (prod[DW-1] == acc[DW-1]) && (sum[DW-1] != prod[DW-1]);
  assign bad = (idx_d == PC) || (idx_n == PC) || (idx_m == PC) || (acc_en && idx_a == PC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      q_set     <= 1'b0;
      q_flag    <= 1'b0;
      unpred    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      q_set     <= in_valid && ovf;
      if (in_valid) begin
        result <= acc_en ? sum : prod;
        unpred <= bad;
        if (ovf) q_flag <= 1'b1;
      end
    end
  end

  // R2
  no_acc_no_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !acc_en) |=> !q_set);
  // R8
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !q_set && $stable(result)));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_flag |=> q_flag);
  // R9
  qset_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_set |-> q_flag);
  // R7
  pc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (idx_n == PC || idx_m == PC || idx_d == PC)) |=> unpred);
endmodule

// File: tb/test_hs_mac.sv
module test_hs_mac;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, mode_wh = 0, acc_en = 0, sel_n = 0, sel_m = 0;
  logic [31:0] op_n = 0, op_m = 0, acc = 0;
  logic [3:0] idx_d = 0, idx_n = 0, idx_m = 0, idx_a = 0;
  logic out_valid, q_set, q_flag, unpred;
  logic [31:0] result;
  int checks = 0, errors = 0;
  logic exp_flag = 0;
  logic [31:0] last_res = 0;

  always #10 clk = ~clk;

  hs_mac i_hs_mac (.clk, .rst_n, .in_valid, .mode_wh, .acc_en, .sel_n, .sel_m,
    .op_n, .op_m, .acc, .idx_d, .idx_n, .idx_m, .idx_a,
    .out_valid, .result, .q_set, .q_flag, .unpred);

  function automatic logic [31:0] mprod(input logic wh, input logic sn, input logic sm,
                                        input logic [31:0] n, input logic [31:0] m);
    logic [15:0] a, b;
    logic [63:0] w;
    a = sn ? n[31:16] : n[15:0];
    b = sm ? m[31:16] : m[15:0];
    if (wh) begin
      w = {{32{n[31]}}, n} * {{48{b[15]}}, b};
      return w[47:16];
    end
    w = {{48{a[15]}}, a} * {{48{b[15]}}, b};
    return w[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic wh, input logic ae, input logic sn, input logic sm,
                     input logic [31:0] n, input logic [31:0] m, input logic [31:0] a,
                     input logic [3:0] d, input logic [3:0] xn, input logic [3:0] xm,
                     input logic [3:0] xa, input string req);
    logic [31:0] p, s, e;
    logic o, u;
    p = mprod(wh, sn, sm, n, m);
    s = p + a;
    o = ae && (p[31] == a[31]) && (s[31] != p[31]);
    e = ae ? s : p;
    u = (d == 15) || (xn == 15) || (xm == 15) || (ae && xa == 15);
    mode_wh = wh; acc_en = ae; sel_n = sn; sel_m = sm;
    op_n = n; op_m = m; acc = a; idx_d = d; idx_n = xn; idx_m = xm; idx_a = xa;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    if (o) exp_flag = 1;
    last_res = e;
    chk({req, " result"}, result, e);
    chk("R8 valid", {31'b0, out_valid}, 32'd1);
    chk(ae ? "R3 q_set" : "R2 q_set", {31'b0, q_set}, {31'b0, o});
    chk("R9 q_flag", {31'b0, q_flag}, {31'b0, exp_flag});
    chk("R7 unpred", {31'b0, unpred}, {31'b0, u});
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset valid", {31'b0, out_valid}, 0);
    chk("R9 reset flag", {31'b0, q_flag}, 0);
    chk("R9 reset result", result, 0);
    chk("R9 reset qset", {31'b0, q_set}, 0);
    // R1 selection combos
    run(0, 0, 1, 0, 32'h0003_FFFE, 32'h8000_0005, 0, 1, 2, 3, 4, "R1 top*bot");
    run(0, 0, 0, 1, 32'h0003_FFFE, 32'h8000_0005, 0, 1, 2, 3, 4, "R1 bot*top");
    run(0, 0, 1, 1, 32'h8000_0000, 32'h8000_0000, 0, 1, 2, 3, 4, "R1 min*min");
    // R2 no Q even with huge values; acc index 15 ignored without accumulate (R7)
    run(0, 0, 0, 0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 1, 2, 3, 15, "R2 noacc");
    // R3 / R6 positive overflow wraps
    run(0, 1, 0, 0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 1, 2, 3, 4, "R6 wrap");
    chk("R6 wrap value", result, 32'hBFFF_0000);
    // R3 negative overflow
    run(0, 1, 1, 0, 32'h8000_0000, 32'h0000_7FFF, 32'h8000_0000, 1, 2, 3, 4, "R3 neg");
    // R4 word by halfword
    run(1, 0, 1, 1, 32'h8000_0000, 32'h8000_1234, 0, 1, 2, 3, 4, "R4 ext");
    chk("R4 value", result, 32'h4000_0000);
    run(1, 0, 0, 0, 32'h1234_5678, 32'hFFFF_FFFF, 0, 1, 2, 3, 4, "R4 minus1");
    // R5 wh accumulate overflow
    run(1, 1, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_0000, 32'h7FFF_FFFF, 1, 2, 3, 4, "R5 ovf");
    // R7 each index
    run(0, 1, 0, 0, 5, 6, 7, 15, 2, 3, 4, "R7 d");
    run(0, 1, 0, 0, 5, 6, 7, 1, 2, 3, 15, "R7 a");
    // R8 idle holds
    @(negedge clk);
    chk("R8 idle valid", {31'b0, out_valid}, 0);
    chk("R8 idle hold", result, last_res);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rn, rm, ra;
      rn = $urandom; rm = $urandom; ra = $urandom;
      if (i % 5 == 0) rn[31:16] = 16'h8000;
      run($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, rn, rm, ra,
          4'($urandom % 16), 4'($urandom % 16), 4'($urandom % 16), 4'($urandom % 16),
          "R1 R3 R4 R5 random");
      if (i % 7 == 0) @(negedge clk);
    end
    chk("R9 sticky end", {31'b0, q_flag}, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule